// File: doc/BRIEF.md
# Triple-Lane Median Select Voter

This block sits behind three redundant computation lanes that all work on the same input frame. When a frame strobe arrives, it takes the three signed lane results and passes one voted value downstream. With all lanes healthy, the voted value is the median of the three results. A single wild result therefore never reaches the output, even before that lane has been identified as bad. The block also names the lane in command, which is the lane that supplied the voted value. The remaining lanes act as monitors.

Every accepted frame is also used to judge lane health. Two results agree when their absolute difference is within a tolerance set on an input port. A lane that agrees with neither of the other two lanes for a set number of consecutive frames is flagged faulty and excluded. Its flag stays set until reset or a clear pulse.

With one lane excluded, the block outputs the mean of the two surviving lanes. If those two lanes then keep disagreeing, both are excluded. An alarm is then raised and no further output is produced.

The mode is held in a three-state machine:
- `ST_TRIPLE`: all lanes live, median output.
- `ST_PAIR`: one lane excluded, mean output.
- `ST_ALARM`: two or more lanes excluded, no output.

Its transitions are:
- **degrade** (`ST_TRIPLE` to `ST_PAIR`): one lane becomes flagged.
- **collapse** (`ST_TRIPLE` or `ST_PAIR` to `ST_ALARM`): two or more lanes become flagged.
- **restore** (any state to `ST_TRIPLE`): a clear pulse.

Top module: `tmv_voter`

## Requirements
- R1: In `ST_TRIPLE`, an accepted frame loads the median of the three lane results into `vote_val` at the clock edge that samples `frame_stb`. `vote_new` is high for exactly that one following cycle.
- R2: In `ST_TRIPLE`, `cmd_lane` becomes the lowest-numbered lane whose result equals the median. On a tie, the lower index wins. Lane numbers are 0, 1 and 2, with bit i of `lane_vld` and `lane_fault` belonging to lane i.
- R3: A frame is accepted only when `frame_stb` is high and every non-excluded lane has its `lane_vld` bit set. If a strobed frame is not accepted, `vote_val` and `cmd_lane` hold, `vote_new` stays low, and the frame does not count toward any lane's disagreement run.
- R4: Results x and y agree when |x − y| ≤ `agree_tol`. In `ST_TRIPLE`, a lane that agrees with neither other lane on an accepted frame extends its run of disagreeing frames; any accepted frame on which it agrees resets the run to zero. The lane's `lane_fault` bit is set on the frame whose run reaches `fault_limit`. A `fault_limit` of 0 acts as 1.
- R5: A set `lane_fault` bit stays set until reset or a `clr_faults` pulse. A `clr_faults` pulse clears all flags and runs, clears the alarm and returns the block to `ST_TRIPLE` at the next edge.
- R6: In `ST_PAIR`, the output is the floor of the mean of the two live lanes, and `cmd_lane` is the lower live lane. The excluded lane's result and valid bit have no effect.
- R7: In `ST_PAIR`, if the two live lanes disagree on `fault_limit` consecutive accepted frames, both are flagged and `no_out_alarm` rises. While the alarm is set, no frame produces `vote_new`.
- R8: After reset, `vote_val` is 0, `vote_new` is 0, `cmd_lane` is 0, `lane_fault` is 000 and `no_out_alarm` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lane0_val | input | DW | Lane 0 signed result |
| lane1_val | input | DW | Lane 1 signed result |
| lane2_val | input | DW | Lane 2 signed result |
| lane_vld | input | 3 | Per-lane result valid, bit i is lane i |
| frame_stb | input | 1 | One-cycle frame strobe |
| agree_tol | input | DW | Unsigned agreement tolerance |
| fault_limit | input | CNT_W | Consecutive disagreeing frames before a lane is flagged |
| clr_faults | input | 1 | Clears all fault flags and runs |
| vote_val | output | DW | Registered voted value |
| vote_new | output | 1 | One-cycle pulse: vote_val was updated |
| cmd_lane | output | 2 | Index of the commanding lane |
| lane_fault | output | 3 | Sticky per-lane exclusion flags |
| no_out_alarm | output | 1 | Two or more lanes excluded, no output |

## Verification
The median path is driven with the outlier in each lane position, with negative values, and with two lanes tied. Together these show a true median selector apart from a mean or a fixed-lane pick, and they confirm the lower-index tie rule for command.

The fault path is driven with an outlier whose run is broken by a frame that sits exactly at the tolerance edge. It is also driven with a run interrupted by a frame that is not accepted. These show whether agreement uses an inclusive bound and whether runs really count only consecutive accepted frames.

Pair mode is driven with a garbage, invalid excluded lane and with a negative odd sum. This exposes any dependence on the excluded lane and any wrong rounding of the mean. A zero limit and a clear pulse cover the two ends of the flag lifetime.

// File: rtl/tmv_pkg.sv
package tmv_pkg;

    typedef enum logic [1:0] {
        ST_TRIPLE = 2'd0,
        ST_PAIR   = 2'd1,
        ST_ALARM  = 2'd2
    } vote_mode_t;

    // Index of the lowest set bit of a three-bit mask (0 when empty).
    function automatic logic [1:0] low_idx3(input logic [2:0] m);
        if (m[0])      return 2'd0;
        else if (m[1]) return 2'd1;
        else if (m[2]) return 2'd2;
        else           return 2'd0;
    endfunction

    function automatic logic [1:0] pop3(input logic [2:0] m);
        return {1'b0, m[0]} + {1'b0, m[1]} + {1'b0, m[2]};
    endfunction

endpackage

// File: rtl/tmv_agree.sv
// Pairwise tolerance comparison. pair_ok[k] is the agreement of the two
// lanes other than lane k, so the index names the lane left out.
module tmv_agree #(
    parameter int DW = 16
) (
    input  logic signed [DW-1:0] lane0_val,
    input  logic signed [DW-1:0] lane1_val,
    input  logic signed [DW-1:0] lane2_val,
    input  logic        [DW-1:0] agree_tol,
    output logic        [2:0]    pair_ok
);
    localparam int XW = DW + 1;

    logic signed [DW-1:0] v [3];
    assign v[0] = lane0_val;
    assign v[1] = lane1_val;
    assign v[2] = lane2_val;

    for (genvar k = 0; k < 3; k++) begin : g_pair
        localparam int IA = (k == 0) ? 1 : 0;
        localparam int IB = (k == 2) ? 1 : 2;
        logic [XW-1:0] diff;
        logic [XW-1:0] mag;
        assign diff = {v[IA][DW-1], v[IA]} - {v[IB][DW-1], v[IB]};
        assign mag  = diff[XW-1] ? (~diff + 1'b1) : diff;
        assign pair_ok[k] = (mag <= {1'b0, agree_tol});
    end

endmodule

// File: rtl/tmv_select.sv
// Value and command-lane selection for the current mode.
module tmv_select
    import tmv_pkg::*;
#(
    parameter int DW = 16
) (
    input  vote_mode_t           mode,
    input  logic signed [DW-1:0] lane0_val,
    input  logic signed [DW-1:0] lane1_val,
    input  logic signed [DW-1:0] lane2_val,
    input  logic        [2:0]    excl,
    output logic signed [DW-1:0] sel_val,
    output logic        [1:0]    sel_cmd
);
    localparam int XW = DW + 1;

    logic signed [DW-1:0] lo01, hi01, mid_hi, med;
    logic signed [DW-1:0] pa, pb;
    logic        [XW-1:0] psum;
    logic        [1:0]    gone;

    always_comb begin
        lo01   = (lane0_val < lane1_val) ? lane0_val : lane1_val;
        hi01   = (lane0_val < lane1_val) ? lane1_val : lane0_val;
        mid_hi = (hi01 < lane2_val) ? hi01 : lane2_val;
        med    = (lo01 < mid_hi) ? mid_hi : lo01;
    end

    always_comb begin
        gone = low_idx3(excl);
        unique case (gone)
            2'd0:    begin pa = lane1_val; pb = lane2_val; end
            2'd1:    begin pa = lane0_val; pb = lane2_val; end
            default: begin pa = lane0_val; pb = lane1_val; end
        endcase
        psum = {pa[DW-1], pa} + {pb[DW-1], pb};
    end

    always_comb begin
        unique case (mode)
            ST_PAIR: begin
                sel_val = psum[XW-1:1];
                sel_cmd = low_idx3(~excl);
            end
            default: begin
                sel_val = med;
                if (lane0_val == med)      sel_cmd = 2'd0;
                else if (lane1_val == med) sel_cmd = 2'd1;
                else                       sel_cmd = 2'd2;
            end
        endcase
    end

endmodule

// File: rtl/tmv_health.sv
// Per-lane consecutive-disagreement runs and sticky exclusion flags.
module tmv_health #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             judge,
    input  logic [2:0]       disagree,
    input  logic [CNT_W-1:0] fault_limit,
    input  logic             clr_faults,
    output logic [2:0]       flag_q,
    output logic [2:0]       flag_d
);
    for (genvar i = 0; i < 3; i++) begin : g_lane
        logic [CNT_W-1:0] run_q, run_d;
        logic [CNT_W:0]   run_inc;

        assign run_inc = {1'b0, run_q} + 1'b1;

        always_comb begin
            run_d     = run_q;
            flag_d[i] = flag_q[i];
            if (clr_faults) begin
                run_d     = '0;
                flag_d[i] = 1'b0;
            end else if (judge && !flag_q[i]) begin
                if (disagree[i]) begin
                    run_d = run_inc[CNT_W-1:0];
                    if (run_inc >= {1'b0, fault_limit})
                        flag_d[i] = 1'b1;
                end else begin
                    run_d = '0;
                end
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                run_q     <= '0;
                flag_q[i] <= 1'b0;
            end else begin
                run_q     <= run_d;
                flag_q[i] <= flag_d[i];
            end
        end
    end

endmodule

// File: rtl/tmv_voter.sv
module tmv_voter
    import tmv_pkg::*;
#(
    parameter int DW    = 16,
    parameter int CNT_W = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic signed [DW-1:0] lane0_val,
    input  logic signed [DW-1:0] lane1_val,
    input  logic signed [DW-1:0] lane2_val,
    input  logic [2:0]           lane_vld,
    input  logic                 frame_stb,
    input  logic [DW-1:0]        agree_tol,
    input  logic [CNT_W-1:0]     fault_limit,
    input  logic                 clr_faults,
    output logic signed [DW-1:0] vote_val,
    output logic                 vote_new,
    output logic [1:0]           cmd_lane,
    output logic [2:0]           lane_fault,
    output logic                 no_out_alarm
);
    vote_mode_t state_q, state_d;

    logic [2:0]           pair_ok;
    logic [2:0]           flag_d;
    logic [2:0]           disagree;
    logic                 accept, judge;
    logic signed [DW-1:0] sel_val;
    logic [1:0]           sel_cmd;

    assign accept = frame_stb && (&(lane_vld | lane_fault));
    assign judge  = accept && (state_q != ST_ALARM);

    tmv_agree #(.DW(DW)) u_agree (
        .lane0_val (lane0_val),
        .lane1_val (lane1_val),
        .lane2_val (lane2_val),
        .agree_tol (agree_tol),
        .pair_ok   (pair_ok)
    );

    // Who disagrees this frame depends on how many lanes still vote.
    always_comb begin
        unique case (state_q)
            ST_TRIPLE: disagree = {~(pair_ok[1] | pair_ok[0]),
                                   ~(pair_ok[2] | pair_ok[0]),
                                   ~(pair_ok[2] | pair_ok[1])};
            ST_PAIR:   disagree = ~lane_fault &
                                  {3{~pair_ok[low_idx3(lane_fault)]}};
            default:   disagree = 3'b000;
        endcase
    end

    tmv_health #(.CNT_W(CNT_W)) u_health (
        .clk         (clk),
        .rst_n       (rst_n),
        .judge       (judge),
        .disagree    (disagree),
        .fault_limit (fault_limit),
        .clr_faults  (clr_faults),
        .flag_q      (lane_fault),
        .flag_d      (flag_d)
    );

    tmv_select #(.DW(DW)) u_select (
        .mode      (state_q),
        .lane0_val (lane0_val),
        .lane1_val (lane1_val),
        .lane2_val (lane2_val),
        .excl      (lane_fault),
        .sel_val   (sel_val),
        .sel_cmd   (sel_cmd)
    );

    // Transitions: degrade, collapse, restore.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_TRIPLE: begin
                if (pop3(flag_d) >= 2'd2)      state_d = ST_ALARM;
                else if (pop3(flag_d) == 2'd1) state_d = ST_PAIR;
            end
            ST_PAIR: begin
                if (pop3(flag_d) >= 2'd2)      state_d = ST_ALARM;
                else if (pop3(flag_d) == 2'd0) state_d = ST_TRIPLE;
            end
            ST_ALARM: begin
                if (pop3(flag_d) == 2'd0)      state_d = ST_TRIPLE;
            end
            default: state_d = ST_TRIPLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_TRIPLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vote_val     <= '0;
            vote_new     <= 1'b0;
            cmd_lane     <= 2'd0;
            no_out_alarm <= 1'b0;
        end else begin
            vote_new     <= 1'b0;
            no_out_alarm <= (state_d == ST_ALARM);
            if (judge) begin
                vote_val <= sel_val;
                cmd_lane <= sel_cmd;
                vote_new <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/tmv_voter_chk.sv
module tmv_voter_chk #(
    parameter int DW = 16
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [2:0]           lane_vld,
    input logic                 frame_stb,
    input logic                 clr_faults,
    input logic signed [DW-1:0] vote_val,
    input logic                 vote_new,
    input logic [1:0]           cmd_lane,
    input logic [2:0]           lane_fault,
    input logic                 no_out_alarm
);
    AST_NEW_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        vote_new |-> $past(frame_stb)); // R1

    AST_CMD_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_lane != 2'd3); // R2

    AST_HOLD_WHEN_REJECTED: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_stb && !(&(lane_vld | lane_fault))) |=> (!vote_new && $stable(vote_val))); // R3

    AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_faults |=> ((lane_fault & $past(lane_fault)) == $past(lane_fault))); // R5

    AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (!rst_n)
        clr_faults |=> (lane_fault == 3'b000 && !no_out_alarm)); // R5

    AST_CMD_NOT_EXCLUDED: assert property (@(posedge clk) disable iff (!rst_n)
        vote_new |-> (($past(lane_fault) & (3'b001 << cmd_lane)) == 3'b000)); // R6

    AST_ALARM_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        no_out_alarm |=> !vote_new); // R7

    AST_ALARM_NEEDS_TWO: assert property (@(posedge clk) disable iff (!rst_n)
        no_out_alarm |-> ($countones(lane_fault) >= 2)); // R7

endmodule

bind tmv_voter tmv_voter_chk #(.DW(DW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .lane_vld     (lane_vld),
    .frame_stb    (frame_stb),
    .clr_faults   (clr_faults),
    .vote_val     (vote_val),
    .vote_new     (vote_new),
    .cmd_lane     (cmd_lane),
    .lane_fault   (lane_fault),
    .no_out_alarm (no_out_alarm)
);

// File: tb/tmv_voter_test.sv
module tmv_voter_test;
    localparam int DW    = 16;
    localparam int CNT_W = 4;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic signed [DW-1:0] lane0_val = '0, lane1_val = '0, lane2_val = '0;
    logic [2:0]           lane_vld = 3'b000;
    logic                 frame_stb = 1'b0;
    logic [DW-1:0]        agree_tol = '0;
    logic [CNT_W-1:0]     fault_limit = '0;
    logic                 clr_faults = 1'b0;
    logic signed [DW-1:0] vote_val;
    logic                 vote_new;
    logic [1:0]           cmd_lane;
    logic [2:0]           lane_fault;
    logic                 no_out_alarm;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    tmv_voter #(.DW(DW), .CNT_W(CNT_W)) uut (.*);

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Drive one strobed frame, sample after the capturing edge.
    task automatic frame(input int a, input int b, input int c, input logic [2:0] v);
        @(negedge clk);
        lane0_val = a[DW-1:0]; lane1_val = b[DW-1:0]; lane2_val = c[DW-1:0];
        lane_vld  = v;
        frame_stb = 1'b1;
        @(negedge clk);
        frame_stb = 1'b0;
    endtask

    task automatic pulse_clear();
        @(negedge clk);
        clr_faults = 1'b1;
        @(negedge clk);
        clr_faults = 1'b0;
    endtask

    task automatic t_reset();
        chk("R8 val", int'(vote_val), 0);
        chk("R8 new", int'(vote_new), 0);
        chk("R8 cmd", int'(cmd_lane), 0);
        chk("R8 fault", int'(lane_fault), 0);
        chk("R8 alarm", int'(no_out_alarm), 0);
    endtask

    task automatic t_median();
        agree_tol = 16'd1000; fault_limit = 4'd3;
        frame(5, 10, 7, 3'b111);
        chk("R1 median outlier lane1", int'(vote_val), 7);
        chk("R1 new pulse", int'(vote_new), 1);
        chk("R2 cmd", int'(cmd_lane), 2);
        @(negedge clk);
        chk("R1 new drops", int'(vote_new), 0);
        frame(-3, -8, 4, 3'b111);
        chk("R1 negative median", int'(vote_val), -3);
        chk("R2 cmd", int'(cmd_lane), 0);
        frame(100, 100, -50, 3'b111);
        chk("R1 tied median", int'(vote_val), 100);
        chk("R2 tie lowest lane", int'(cmd_lane), 0);
        frame(2, 5, 5, 3'b111);
        chk("R2 tie lanes 1 2", int'(cmd_lane), 1);
        chk("R1 median", int'(vote_val), 5);
    endtask

    task automatic t_valid_gate();
        frame(40, 41, 42, 3'b101);
        chk("R3 no new on missing valid", int'(vote_new), 0);
        chk("R3 value holds", int'(vote_val), 5);
        chk("R3 cmd holds", int'(cmd_lane), 1);
    endtask

    task automatic t_persist();
        pulse_clear();
        agree_tol = 16'd2; fault_limit = 4'd3;
        frame(10, 11, 50, 3'b111);
        chk("R1 outlier blocked", int'(vote_val), 11);
        frame(10, 11, 50, 3'b111);
        chk("R4 two runs no flag", int'(lane_fault), 0);
        frame(0, 2, 4, 3'b111);   // diff of 2 agrees: resets lane2 run
        chk("R4 tolerance edge median", int'(vote_val), 2);
        frame(10, 11, 50, 3'b111);
        frame(10, 11, 50, 3'b110); // rejected: must not count (R3)
        chk("R3 rejected no new", int'(vote_new), 0);
        frame(10, 11, 50, 3'b111);
        chk("R4 run reset and rejected not counted", int'(lane_fault), 0);
        frame(10, 11, 50, 3'b111);
        chk("R4 flag on third run", int'(lane_fault), 4);
        chk("R1 value while flagging", int'(vote_val), 11);
    endtask

    task automatic t_pair();
        frame(3, 4, 999, 3'b011);
        chk("R6 new with excluded invalid", int'(vote_new), 1);
        chk("R6 mean", int'(vote_val), 3);
        chk("R6 cmd lowest live", int'(cmd_lane), 0);
        frame(-3, -4, 7777, 3'b011);
        chk("R6 floor mean negative", int'(vote_val), -4);
        frame(9, 9, 9, 3'b101);
        chk("R3 pair missing live lane", int'(vote_new), 0);
        chk("R3 pair value holds", int'(vote_val), -4);
    endtask

    task automatic t_sticky();
        frame(7, 7, 7, 3'b111);
        chk("R5 flag sticky", int'(lane_fault), 4);
        chk("R6 mean equal", int'(vote_val), 7);
    endtask

    task automatic t_alarm();
        frame(0, 100, 0, 3'b111);
        chk("R7 pair mean", int'(vote_val), 50);
        frame(0, 100, 0, 3'b111);
        chk("R7 not yet", int'(lane_fault), 4);
        frame(0, 100, 0, 3'b111);
        chk("R7 both flagged", int'(lane_fault), 7);
        chk("R7 alarm", int'(no_out_alarm), 1);
        frame(1, 1, 1, 3'b111);
        chk("R7 no output in alarm", int'(vote_new), 0);
        chk("R7 value frozen", int'(vote_val), 50);
    endtask

    task automatic t_clear();
        pulse_clear();
        chk("R5 clear flags", int'(lane_fault), 0);
        chk("R5 clear alarm", int'(no_out_alarm), 0);
        frame(1, 2, 3, 3'b111);
        chk("R5 median after clear", int'(vote_val), 2);
        chk("R5 new after clear", int'(vote_new), 1);
    endtask

    task automatic t_zero_limit();
        fault_limit = 4'd0;
        frame(0, 1, 90, 3'b111);
        chk("R4 limit 0 flags at once", int'(lane_fault), 4);
        chk("R1 blocked", int'(vote_val), 1);
        pulse_clear();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_median();
        t_valid_gate();
        t_persist();
        t_pair();
        t_sticky();
        t_alarm();
        t_clear();
        t_zero_limit();
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL R1 watchdog: actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule